// File: doc/BRIEF.md
# Three-Wire Control Bus Master

This block drives a write-only control bus made of three lines: a serial clock, a serial data line and a mode line. The mode line tells the target whether the byte on the wire is the target address or a payload byte. A host hands the block an address byte, a payload byte count and six timing values, then raises a start request. The block sends the address while mode is low, then sends each payload byte while mode is high. Between two payload bytes it pulses mode low.

Payload bytes arrive one at a time on a valid/ready input. The block asks for each byte at the end of the wait that comes before that byte's mode setup interval. If no byte is offered, that wait is stretched until one is. Each timing interval is counted in system clock cycles. A zero value is treated as one cycle. All six values are captured when the start request is accepted.

Top module: `tw_serial_master`

## Requirements
- R1: Out of reset and whenever no transfer is running, the serial clock is high, data is high, mode is low, and busy, done and din_ready are all low.
- R2: An accepted start first drives mode high, with clock and data high, for the mode interval. It then drives mode low for the mode setup interval before the first clock fall.
- R3: Each bit is framed in the same way. The clock is low with data unchanged for the data hold interval. The clock stays low with the new bit on data for the data setup interval. The clock is then high for the clock high interval. Bits are sent least significant bit first (bit 0 first), and data does not change while the clock is high.
- R4: The address byte is sent with mode low. After its last bit, the lines hold, with mode still low, for the mode hold interval.
- R5: Each payload byte is sent with mode high. Mode rises, with the clock high, for the mode setup interval before the byte's first clock fall.
- R6: Between two payload bytes, the block holds mode high for the mode hold interval, then drives it low for the mode interval, then raises it again. There is no such low pulse before the first payload byte or after the last.
- R7: An interval value v lasts max(v,1) cycles. The values used are those present on the ports in the cycle the start is accepted. Later changes on those ports have no effect on the running transfer.
- R8: A byte count of zero sends only the opening sequence and the address byte with its mode hold wait, and then ends. din_ready is never raised.
- R9: din_ready is high only in the final cycle of the wait that comes before a payload byte's mode setup interval. A byte is taken when din_valid and din_ready are both high. While din_valid is low, that wait is extended one cycle at a time.
- R10: After the last bit's clock high interval, done is high for exactly one cycle. In that cycle busy is high, the clock is high, data is high and mode is low. In the next cycle the block is idle.
- R11: A start request while busy is high is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer request, accepted only when idle |
| addr_i | input | DW | Address byte |
| nbytes_i | input | CW | Number of payload bytes |
| t_dhold_i | input | TW | Clock-low wait before data changes |
| t_dsetup_i | input | TW | Data-valid wait before the clock rises |
| t_chigh_i | input | TW | Clock high time per bit |
| t_mhold_i | input | TW | Wait after a byte before mode changes |
| t_mode_i | input | TW | Mode pulse length (opening high, inter-byte low) |
| t_msetup_i | input | TW | Mode-to-first-clock-fall wait |
| din_i | input | DW | Payload byte |
| din_valid_i | input | 1 | Payload byte offered |
| din_ready_o | output | 1 | Payload byte taken when valid is also high |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| scl_o | output | 1 | Serial clock line |
| sda_o | output | 1 | Serial data line |
| mode_o | output | 1 | Mode line |

## Verification
The bench computes, from the interval values and bytes alone, the full expected level of all five line and status outputs for every cycle. The sequence starts with the cycle after the clock edge that accepts start and ends with the first idle cycle after done. Every output is a decode of registered state, so each change shows up in the cycle right after the edge that causes it. The bench samples on the falling edge, one trace entry per cycle, and compares each entry in order. Any wrong interval length therefore shows up as a shift in the trace. A stretched fetch wait is modelled by adding the stall cycles to the expected wait. Separate counts check how many bytes were consumed and in how many cycles din_ready was high.

// File: rtl/tw_pkg.sv
package tw_pkg;

   // sequencer states
   typedef enum logic [3:0] {
      S_IDLE,   // lines parked
      S_PRE,    // opening mode-high pulse
      S_ASET,   // mode low before address
      S_BLO,    // clock low, data held
      S_BDS,    // clock low, new bit driven
      S_BHI,    // clock high
      S_AHOLD,  // wait after address byte
      S_GHOLD,  // wait after a payload byte (more follow)
      S_GLOW,   // inter-byte mode low pulse
      S_DSET,   // mode high before payload byte
      S_FIN     // one-cycle end marker
   } tw_state_e;

   // interval slot indices
   localparam int IV_DHOLD  = 0;
   localparam int IV_DSETUP = 1;
   localparam int IV_CHIGH  = 2;
   localparam int IV_MHOLD  = 3;
   localparam int IV_MODE   = 4;
   localparam int IV_MSETUP = 5;
   localparam int IV_N      = 6;

endpackage

// File: rtl/tw_interval_timer.sv
module tw_interval_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          exp_o
);

   logic [TW-1:0] cnt_q;

   // a load of v gives max(v,1) cycles before expiry is seen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= (val_i == '0) ? '0 : val_i - TW'(1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - TW'(1);
   end

   assign exp_o = (cnt_q == '0);

endmodule

// File: rtl/tw_bit_shifter.sv
module tw_bit_shifter #(
   parameter int DW        = 8,
   parameter int LSB_FIRST = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] data_i,
   input  logic          step_i,
   output logic          bit_o,
   output logic          last_o
);

   localparam int IW = (DW > 1) ? $clog2(DW) : 1;

   logic [DW-1:0] byte_q;
   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
         idx_q  <= '0;
      end else if (load_i) begin
         byte_q <= data_i;
         idx_q  <= '0;
      end else if (step_i) begin
         idx_q  <= (idx_q == IW'(DW-1)) ? '0 : idx_q + IW'(1);
      end
   end

   generate
      if (LSB_FIRST != 0) begin : g_lsb
         assign bit_o = byte_q[idx_q];
      end else begin : g_msb
         assign bit_o = byte_q[IW'(DW-1) - idx_q];
      end
   endgenerate

   assign last_o = (idx_q == IW'(DW-1));

endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
   import tw_pkg::*;
#(
   parameter int TW        = 8,
   parameter int CW        = 4,
   parameter int DW        = 8,
   parameter int LSB_FIRST = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] addr_i,
   input  logic [CW-1:0] nbytes_i,
   input  logic [TW-1:0] t_dhold_i,
   input  logic [TW-1:0] t_dsetup_i,
   input  logic [TW-1:0] t_chigh_i,
   input  logic [TW-1:0] t_mhold_i,
   input  logic [TW-1:0] t_mode_i,
   input  logic [TW-1:0] t_msetup_i,
   input  logic [DW-1:0] din_i,
   input  logic          din_valid_i,
   output logic          din_ready_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          scl_o,
   output logic          sda_o,
   output logic          mode_o
);

   generate
      if (TW < 1) begin : g_bad_tw
         $error("TW must be at least 1");
      end
      if (CW < 1) begin : g_bad_cw
         $error("CW must be at least 1");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW must be at least 2");
      end
   endgenerate

   typedef logic [IV_N-1:0][TW-1:0] iv_vec_t;

   iv_vec_t   iv_port, iv_q, iv_use;
   tw_state_e st, ns;
   logic [CW-1:0] left_q;
   logic      ph_data_q, sda_q;
   logic      tmr_exp, go, wants_byte, accept;
   logic      cur_bit, bit_last, load_sh, step;
   logic [DW-1:0] load_data;
   logic [TW-1:0] ld_val;

   assign iv_port[IV_DHOLD]  = t_dhold_i;
   assign iv_port[IV_DSETUP] = t_dsetup_i;
   assign iv_port[IV_CHIGH]  = t_chigh_i;
   assign iv_port[IV_MHOLD]  = t_mhold_i;
   assign iv_port[IV_MODE]   = t_mode_i;
   assign iv_port[IV_MSETUP] = t_msetup_i;

   function automatic logic [TW-1:0] pick(tw_state_e s, iv_vec_t iv);
      case (s)
         S_PRE, S_GLOW:    return iv[IV_MODE];
         S_ASET, S_DSET:   return iv[IV_MSETUP];
         S_BLO:            return iv[IV_DHOLD];
         S_BDS:            return iv[IV_DSETUP];
         S_BHI:            return iv[IV_CHIGH];
         S_AHOLD, S_GHOLD: return iv[IV_MHOLD];
         default:          return '0;
      endcase
   endfunction

   // next-state selection
   always_comb begin
      ns = st;
      case (st)
         S_IDLE:  ns = S_PRE;
         S_PRE:   ns = S_ASET;
         S_ASET:  ns = S_BLO;
         S_BLO:   ns = S_BDS;
         S_BDS:   ns = S_BHI;
         S_BHI: begin
            if (!bit_last)       ns = S_BLO;
            else if (!ph_data_q) ns = S_AHOLD;
            else if (left_q != '0) ns = S_GHOLD;
            else                 ns = S_FIN;
         end
         S_AHOLD: ns = (left_q == '0) ? S_FIN : S_DSET;
         S_GHOLD: ns = S_GLOW;
         S_GLOW:  ns = S_DSET;
         S_DSET:  ns = S_BLO;
         S_FIN:   ns = S_IDLE;
         default: ns = S_IDLE;
      endcase
   end

   assign wants_byte  = (st != S_IDLE) && (ns == S_DSET);
   assign din_ready_o = (st != S_IDLE) && tmr_exp && wants_byte;
   assign accept      = din_ready_o && din_valid_i;
   assign go          = (st == S_IDLE) ? start_i
                                       : (tmr_exp && (!wants_byte || din_valid_i));
   assign iv_use      = (st == S_IDLE) ? iv_port : iv_q;
   assign ld_val      = pick(ns, iv_use);
   assign load_sh     = ((st == S_IDLE) && start_i) || accept;
   assign load_data   = accept ? din_i : addr_i;
   assign step        = go && (st == S_BHI);

   tw_interval_timer #(.TW(TW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (go),
      .val_i  (ld_val),
      .exp_o  (tmr_exp)
   );

   tw_bit_shifter #(.DW(DW), .LSB_FIRST(LSB_FIRST)) u_shf (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_sh),
      .data_i (load_data),
      .step_i (step),
      .bit_o  (cur_bit),
      .last_o (bit_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         iv_q      <= '0;
         left_q    <= '0;
         ph_data_q <= 1'b0;
         sda_q     <= 1'b1;
      end else begin
         if (go) st <= ns;
         if ((st == S_IDLE) && start_i) begin
            iv_q      <= iv_port;
            left_q    <= nbytes_i;
            ph_data_q <= 1'b0;
         end else if (accept) begin
            left_q    <= left_q - CW'(1);
            ph_data_q <= 1'b1;
         end
         if (st == S_IDLE)     sda_q <= 1'b1;
         else if (st == S_BHI) sda_q <= cur_bit;
      end
   end

   // line decode from registered state
   always_comb begin
      scl_o  = 1'b1;
      sda_o  = sda_q;
      mode_o = 1'b0;
      case (st)
         S_IDLE, S_FIN: sda_o = 1'b1;
         S_PRE:   begin sda_o = 1'b1; mode_o = 1'b1; end
         S_ASET:  sda_o = 1'b1;
         S_BLO:   begin scl_o = 1'b0; mode_o = ph_data_q; end
         S_BDS:   begin scl_o = 1'b0; sda_o = cur_bit; mode_o = ph_data_q; end
         S_BHI:   begin sda_o = cur_bit; mode_o = ph_data_q; end
         S_GHOLD, S_DSET: mode_o = 1'b1;
         default: mode_o = 1'b0;
      endcase
   end

   assign busy_o = (st != S_IDLE);
   assign done_o = (st == S_FIN);

endmodule

// File: rtl/tw_serial_master_chk.sv
module tw_serial_master_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic din_ready_o,
   input logic scl_o,
   input logic sda_o,
   input logic mode_o
);

   p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (scl_o && sda_o && !mode_o && !done_o && !din_ready_o));

   p_data_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o && $past(scl_o) && busy_o && !done_o) |-> $stable(sda_o));

   p_mode_moves_clk_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_o) |-> scl_o);

   p_ready_in_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      din_ready_o |-> (busy_o && scl_o && !done_o));

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   p_done_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_o && scl_o && sda_o && !mode_o));

   p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

endmodule

bind tw_serial_master tw_serial_master_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .din_ready_o (din_ready_o),
   .scl_o       (scl_o),
   .sda_o       (sda_o),
   .mode_o      (mode_o)
);

// File: tb/tw_serial_master_tb.sv
module tw_serial_master_tb;

   localparam int CLK_P = 10;
   localparam int TW = 8;
   localparam int CW = 4;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [DW-1:0] addr = '0;
   logic [CW-1:0] nbytes = '0;
   logic [TW-1:0] t_dh = '0, t_ds = '0, t_ch = '0, t_mh = '0, t_md = '0, t_ms = '0;
   logic [DW-1:0] din;
   logic din_valid, din_ready, busy, done, scl, sda, mode;

   logic feed_en = 1'b1;
   int   fidx = 0;
   logic [DW-1:0] bytes_q [0:7];

   int n_chk = 0;
   int n_bad = 0;

   logic [4:0] tr [0:4095];
   int   tl;
   logic tr_prev;

   always #(CLK_P/2) clk = ~clk;

   assign din       = bytes_q[fidx & 7];
   assign din_valid = feed_en;

   always @(posedge clk) if (din_ready && din_valid) fidx <= fidx + 1;

   tw_serial_master #(.TW(TW), .CW(CW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .nbytes_i(nbytes),
      .t_dhold_i(t_dh), .t_dsetup_i(t_ds), .t_chigh_i(t_ch), .t_mhold_i(t_mh),
      .t_mode_i(t_md), .t_msetup_i(t_ms), .din_i(din), .din_valid_i(din_valid),
      .din_ready_o(din_ready), .busy_o(busy), .done_o(done),
      .scl_o(scl), .sda_o(sda), .mode_o(mode)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int dur(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic push(input logic s, input logic d, input logic m,
                       input logic b, input logic dn, input int n);
      for (int k = 0; k < n; k++) begin
         tr[tl] = {s, d, m, b, dn};
         tl++;
      end
   endtask

   task automatic put_byte(input logic [7:0] v, input logic m,
                           input int dh, input int ds, input int ch);
      for (int b = 0; b < 8; b++) begin
         push(1'b0, tr_prev, m, 1'b1, 1'b0, dur(dh));
         push(1'b0, v[b],   m, 1'b1, 1'b0, dur(ds));
         push(1'b1, v[b],   m, 1'b1, 1'b0, dur(ch));
         tr_prev = v[b];
      end
   endtask

   // expected per-cycle trace {scl,sda,mode,busy,done}
   task automatic build(input logic [7:0] a, input int n, input int dh, input int ds,
                        input int ch, input int mh, input int md, input int ms, input int stall);
      tl = 0;
      tr_prev = 1'b1;
      push(1, 1, 1, 1, 0, dur(md));
      push(1, 1, 0, 1, 0, dur(ms));
      put_byte(a, 1'b0, dh, ds, ch);
      push(1, tr_prev, 0, 1, 0, dur(mh) + ((n > 0) ? stall : 0));
      for (int k = 0; k < n; k++) begin
         if (k > 0) begin
            push(1, tr_prev, 1, 1, 0, dur(mh));
            push(1, tr_prev, 0, 1, 0, dur(md));
         end
         push(1, tr_prev, 1, 1, 0, dur(ms));
         put_byte(bytes_q[k], 1'b1, dh, ds, ch);
      end
      push(1, 1, 0, 1, 1, 1);
      push(1, 1, 0, 0, 0, 1);
   endtask

   task automatic run(input string tag, input logic [7:0] a, input int n,
                      input int dh, input int ds, input int ch, input int mh,
                      input int md, input int ms, input int stall, input bit mid);
      int bad_at = -1;
      logic [4:0] act_at = '0, exp_at = '0;
      int rdy = 0;
      int waited = 0;
      bit seen = 0;
      build(a, n, dh, ds, ch, mh, md, ms, stall);
      @(negedge clk);
      fidx = 0;
      feed_en = (stall == 0);
      addr = a; nbytes = CW'(n);
      t_dh = TW'(dh); t_ds = TW'(ds); t_ch = TW'(ch);
      t_mh = TW'(mh); t_md = TW'(md); t_ms = TW'(ms);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < tl; i++) begin
         if (bad_at < 0 && {scl, sda, mode, busy, done} !== tr[i]) begin
            bad_at = i; act_at = {scl, sda, mode, busy, done}; exp_at = tr[i];
         end
         if (din_ready) rdy++;
         if (!feed_en) begin
            if (din_ready) seen = 1;
            if (seen) begin
               if (waited == stall) feed_en = 1'b1;
               else waited++;
            end
         end
         if (mid && i == 5) begin
            // R11 / R7: new start and new intervals while busy
            start = 1'b1; addr = ~a; nbytes = CW'(n + 1);
            t_dh = TW'(dh + 3); t_ch = TW'(ch + 2); t_md = TW'(md + 4);
         end
         if (mid && i == 6) start = 1'b0;
         @(negedge clk);
      end
      chk(bad_at < 0, {tag, " trace (first bad cycle shown)"}, {27'd0, act_at}, {27'd0, exp_at});
      chk(fidx == n, {tag, " R9 bytes consumed"}, fidx, n);
      chk(rdy == n + ((n > 0) ? stall : 0), {tag, " R9 ready cycles"}, rdy, n + ((n > 0) ? stall : 0));
      feed_en = 1'b1;
   endtask

   task automatic t_reset;
      chk(scl === 1'b1, "R1 reset scl", scl, 1);
      chk(sda === 1'b1, "R1 reset sda", sda, 1);
      chk(mode === 1'b0, "R1 reset mode", mode, 0);
      chk(busy === 1'b0, "R1 reset busy", busy, 0);
      chk(done === 1'b0, "R1 reset done", done, 0);
      chk(din_ready === 1'b0, "R1 reset ready", din_ready, 0);
   endtask

   task automatic t_min_single;
      bytes_q[0] = 8'hA5;
      run("R2 R3 R5 R7 R10 zero intervals one byte", 8'h16, 1, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_multi;
      bytes_q[0] = 8'h3C; bytes_q[1] = 8'h81; bytes_q[2] = 8'hFE;
      run("R3 R4 R5 R6 R10 three bytes mixed intervals", 8'h6B, 3, 2, 1, 3, 2, 3, 2, 0, 0);
   endtask

   task automatic t_addr_only;
      run("R8 R4 zero count", 8'hC3, 0, 1, 2, 1, 3, 2, 1, 0, 0);
   endtask

   task automatic t_stall;
      bytes_q[0] = 8'h5A; bytes_q[1] = 8'h01;
      run("R9 R6 stalled first byte", 8'h14, 2, 1, 1, 1, 2, 1, 1, 4, 0);
   endtask

   task automatic t_busy_start;
      bytes_q[0] = 8'h96; bytes_q[1] = 8'h0F;
      run("R11 R7 start and interval change while busy", 8'h29, 2, 1, 2, 1, 1, 2, 3, 0, 1);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) bytes_q[i] = '0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_min_single;
      t_multi;
      t_addr_only;
      t_stall;
      t_busy_start;
      t_min_single;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule